// File: doc/BRIEF.md
# Floating-Point Class Mask Unit

This purely combinational unit inspects one floating-point operand and reports which of ten value categories it falls into. The result is a one-hot mask, zero-extended to the integer result width. The operand arrives on a 64-bit word. A 2-bit format select chooses between single precision, which uses the low 32 bits, and double precision, which uses the whole word. Internally the unit splits the operand into sign, exponent and fraction for both precisions at once. It picks the set of field flags that belongs to the selected format and turns them into one class index, which is then expanded into the mask.

The mask keeps positive and negative zeros apart, and keeps them apart from subnormals of either sign. It also separates the two kinds of not-a-number. The bit positions are fixed, because downstream integer code tests individual bits of the result.

Top module: `fp_class_mask`

## Requirements
- R1: A negative infinity sets mask bit 0 only, a negative normal number sets bit 1 only, and a negative subnormal number sets bit 2 only.
- R2: A negative zero sets mask bit 3 only, and a positive zero sets bit 4 only.
- R3: A positive subnormal number sets mask bit 5 only, a positive normal number sets bit 6 only, and a positive infinity sets bit 7 only.
- R4: A NaN sets bit 8 when the most significant fraction bit is 0 (signaling) and bit 9 when that bit is 1 (quiet), whatever the sign bit is.
- R5: For every operand and format, exactly one of bits 9..0 is set and every result bit above bit 9 is 0.
- R6: Format code 2'b00 classifies bits 31..0 as single precision: sign at bit 31, an 8-bit exponent at bits 30..23 and a 23-bit fraction at bits 22..0. Bits 63..32 have no effect on the result.
- R7: Format code 2'b01 classifies bits 63..0 as double precision: sign at bit 63, an 11-bit exponent at bits 62..52 and a 52-bit fraction at bits 51..0.
- R8: Format codes 2'b10 and 2'b11 behave like code 2'b00.
- R9: An all-ones exponent is infinity when the fraction is zero and NaN otherwise. An all-zero exponent is zero when the fraction is zero and subnormal otherwise. Every other exponent value, including the largest and the smallest, gives a normal number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 64 | Operand word; single precision values occupy bits 31..0 |
| fmt_i | input | 2 | Format select: 2'b01 double, any other code single |
| class_o | output | 64 | One-hot class mask in bits 9..0, upper bits zero |

## Verification
The unit has no register between `operand_i`/`fmt_i` and `class_o`, so every result is due in the same cycle as its stimulus, with zero cycles of delay. The bench applies each operand and format just after a rising clock edge and reads the mask at the following falling edge. By then the combinational path has settled, and no stimulus change falls in the same time step. Each scenario task compares the mask against a value that the bench decodes itself from the field positions given in R6 and R7. It also counts the set bits, so that it can confirm R5 on every stimulus.

// File: rtl/fpcls_pkg.sv
package fpcls_pkg;

  localparam int unsigned NUM_CLS = 10;
  localparam int unsigned CLS_IW  = 4;

  typedef enum logic [1:0] {
    FMT_SGL = 2'b00,
    FMT_DBL = 2'b01
  } fmt_e;

  // Mask bit index of every category; the order is visible at the result.
  typedef enum logic [CLS_IW-1:0] {
    CLS_NEG_INF  = 4'd0,
    CLS_NEG_NORM = 4'd1,
    CLS_NEG_SUB  = 4'd2,
    CLS_NEG_ZERO = 4'd3,
    CLS_POS_ZERO = 4'd4,
    CLS_POS_SUB  = 4'd5,
    CLS_POS_NORM = 4'd6,
    CLS_POS_INF  = 4'd7,
    CLS_SIG_NAN  = 4'd8,
    CLS_QUI_NAN  = 4'd9
  } cls_e;

  typedef struct packed {
    logic sign;
    logic exp_ones;
    logic exp_zero;
    logic frac_zero;
    logic frac_top;
  } fld_flags_t;

  // Pick the category from the field flags of one operand.
  function automatic cls_e fpcls_pick(input fld_flags_t f);
    cls_e c;
    if (f.exp_ones) begin
      if (!f.frac_zero) c = f.frac_top ? CLS_QUI_NAN : CLS_SIG_NAN;
      else              c = f.sign ? CLS_NEG_INF : CLS_POS_INF;
    end else if (f.exp_zero) begin
      if (f.frac_zero)  c = f.sign ? CLS_NEG_ZERO : CLS_POS_ZERO;
      else              c = f.sign ? CLS_NEG_SUB  : CLS_POS_SUB;
    end else begin
      c = f.sign ? CLS_NEG_NORM : CLS_POS_NORM;
    end
    return c;
  endfunction

endpackage

// File: rtl/fpcls_unpack.sv
module fpcls_unpack
  import fpcls_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W   = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIGN_POS = EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  output fld_flags_t        flags_o
);

  logic [EXP_W-1:0]  exp_fld;
  logic [FRAC_W-1:0] frac_fld;

  assign exp_fld  = word_i[SIGN_POS-1:FRAC_W];
  assign frac_fld = word_i[FRAC_W-1:0];

  assign flags_o.sign      = word_i[SIGN_POS];
  assign flags_o.exp_ones  = &exp_fld;
  assign flags_o.exp_zero  = ~|exp_fld;
  assign flags_o.frac_zero = ~|frac_fld;
  assign flags_o.frac_top  = frac_fld[FRAC_W-1];

endmodule

// File: rtl/fpcls_decode.sv
module fpcls_decode
  import fpcls_pkg::*;
#(
  parameter int unsigned OUT_W = 64
) (
  input  fld_flags_t       flags_i,
  output cls_e             cls_o,
  output logic [OUT_W-1:0] mask_o
);

  assign cls_o = fpcls_pick(flags_i);

  for (genvar g = 0; g < OUT_W; g++) begin : g_bit
    if (g < NUM_CLS) begin : g_cls
      assign mask_o[g] = (cls_o == cls_e'(g));
    end else begin : g_pad
      assign mask_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/fp_class_mask.sv
module fp_class_mask
  import fpcls_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned SP_EXP  = 8,
  parameter int unsigned SP_FRAC = 23,
  parameter int unsigned DP_EXP  = 11,
  parameter int unsigned DP_FRAC = 52,
  localparam int unsigned SP_W   = 1 + SP_EXP + SP_FRAC,
  localparam int unsigned DP_W   = 1 + DP_EXP + DP_FRAC
) (
  input  logic [DP_W-1:0] operand_i,
  input  logic [1:0]      fmt_i,
  output logic [XLEN-1:0] class_o
);

  fld_flags_t sp_flags;
  fld_flags_t dp_flags;
  fld_flags_t sel_flags;
  logic       sel_dbl;
  cls_e       sel_cls;

  fpcls_unpack #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_unpack_sp (
    .word_i (operand_i[SP_W-1:0]),
    .flags_o(sp_flags)
  );

  fpcls_unpack #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_unpack_dp (
    .word_i (operand_i),
    .flags_o(dp_flags)
  );

  assign sel_dbl   = (fmt_i == FMT_DBL);
  assign sel_flags = sel_dbl ? dp_flags : sp_flags;

  fpcls_decode #(.OUT_W(XLEN)) u_decode (
    .flags_i(sel_flags),
    .cls_o  (sel_cls),
    .mask_o (class_o)
  );

endmodule

// File: rtl/fpcls_checker.sv
module fpcls_checker
  import fpcls_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic [63:0]     operand_i,
  input logic [1:0]      fmt_i,
  input logic [XLEN-1:0] class_o,
  input logic            sel_dbl,
  input cls_e            sel_cls
);

  logic        dbl;
  logic        sgn;
  logic        e_ones;
  logic        e_zero;
  logic        f_zero;

  always_comb begin
    dbl    = (fmt_i == 2'b01);
    sgn    = dbl ? operand_i[63] : operand_i[31];
    e_ones = dbl ? (operand_i[62:52] == 11'h7FF) : (operand_i[30:23] == 8'hFF);
    e_zero = dbl ? (operand_i[62:52] == 11'h000) : (operand_i[30:23] == 8'h00);
    f_zero = dbl ? (operand_i[51:0] == 52'd0)    : (operand_i[22:0] == 23'd0);
  end

  always_comb begin
    assert_onehot_R5: assert ($countones(class_o[9:0]) == 1)
      else $error("class mask not one-hot");
    assert_upper_clear_R5: assert (class_o[XLEN-1:10] == '0)
      else $error("class mask upper bits set");
    assert_index_R5: assert (class_o[sel_cls] == 1'b1)
      else $error("class index and mask disagree");
    assert_fmt_sel_R7: assert (sel_dbl == dbl)
      else $error("format selection wrong");
    if (|class_o[3:0]) begin
      assert_neg_sign_R1: assert (sgn)
        else $error("negative class with clear sign");
    end
    if (|class_o[7:4]) begin
      assert_pos_sign_R3: assert (!sgn)
        else $error("positive class with set sign");
    end
    if (class_o[3] | class_o[4]) begin
      assert_zero_fields_R2: assert (e_zero && f_zero)
        else $error("zero class on nonzero magnitude");
    end
    if (class_o[8] | class_o[9]) begin
      assert_nan_fields_R4: assert (e_ones && !f_zero)
        else $error("NaN class on non-NaN fields");
    end
    if (class_o[1] | class_o[6]) begin
      assert_normal_exp_R9: assert (!e_ones && !e_zero)
        else $error("normal class on extreme exponent");
    end
  end

endmodule

bind fp_class_mask fpcls_checker #(.XLEN(XLEN)) u_fpcls_checker (
  .operand_i(operand_i),
  .fmt_i    (fmt_i),
  .class_o  (class_o),
  .sel_dbl  (sel_dbl),
  .sel_cls  (sel_cls)
);

// File: tb/test_fp_class_mask.sv
module test_fp_class_mask;

  logic        clk;
  logic        rst;
  logic [63:0] operand;
  logic [1:0]  fmt;
  logic [63:0] cls;
  int          checks;
  int          failures;
  bit          done;

  fp_class_mask i_fp_class_mask (
    .operand_i(operand),
    .fmt_i    (fmt),
    .class_o  (cls)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Independent decode of the expected mask from the field positions in R6/R7.
  function automatic logic [63:0] want(input logic [63:0] w, input logic [1:0] f);
    logic        s;
    int unsigned e, emax;
    logic        fz, ftop;
    int          idx;
    if (f == 2'b01) begin
      s = w[63]; e = w[62:52]; emax = 2047; fz = (w[51:0] == 0); ftop = w[51];
    end else begin
      s = w[31]; e = w[30:23]; emax = 255; fz = (w[22:0] == 0); ftop = w[22];
    end
    if (e == emax && !fz)      idx = ftop ? 9 : 8;
    else if (e == emax)        idx = s ? 0 : 7;
    else if (e == 0 && fz)     idx = s ? 3 : 4;
    else if (e == 0)           idx = s ? 2 : 5;
    else                       idx = s ? 1 : 6;
    return 64'd1 << idx;
  endfunction

  task automatic apply_check(input logic [63:0] w, input logic [1:0] f,
                             input logic [63:0] exp_mask, input string req);
    @(posedge clk);
    operand <= w;
    fmt     <= f;
    @(negedge clk);
    checks++;
    if (cls !== exp_mask) begin
      failures++;
      $display("FAIL %s op=%h fmt=%b actual=%h expected=%h", req, w, f, cls, exp_mask);
    end
    checks++;
    if ($countones(cls) != 1 || cls[63:10] != 0) begin
      failures++;
      $display("FAIL R5 op=%h fmt=%b actual=%h expected=one bit in 9..0", w, f, cls);
    end
  endtask

  task automatic t_reset_state;
    rst = 1'b1; operand = '0; fmt = 2'b00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (cls !== 64'h10) begin
      failures++;
      $display("FAIL R2 reset state actual=%h expected=%h", cls, 64'h10);
    end
  endtask

  task automatic t_single_classes;
    apply_check(64'hFF800000, 2'b00, 64'h001, "R1 -inf sp");
    apply_check(64'hBF800000, 2'b00, 64'h002, "R1 -norm sp");
    apply_check(64'h80000001, 2'b00, 64'h004, "R1 -sub sp");
    apply_check(64'h80000000, 2'b00, 64'h008, "R2 -0 sp");
    apply_check(64'h00000000, 2'b00, 64'h010, "R2 +0 sp");
    apply_check(64'h007FFFFF, 2'b00, 64'h020, "R3 +sub sp");
    apply_check(64'h3F800000, 2'b00, 64'h040, "R3 +norm sp");
    apply_check(64'h7F800000, 2'b00, 64'h080, "R3 +inf sp");
    apply_check(64'h7F800001, 2'b00, 64'h100, "R4 snan sp");
    apply_check(64'h7FC00000, 2'b00, 64'h200, "R4 qnan sp");
    apply_check(64'hFFC00000, 2'b00, 64'h200, "R4 neg qnan sp");
    apply_check(64'hFFBFFFFF, 2'b00, 64'h100, "R4 neg snan sp");
  endtask

  task automatic t_double_classes;
    apply_check(64'hFFF0000000000000, 2'b01, 64'h001, "R7 -inf dp");
    apply_check(64'hBFF0000000000000, 2'b01, 64'h002, "R7 -norm dp");
    apply_check(64'h8000000000000001, 2'b01, 64'h004, "R7 -sub dp");
    apply_check(64'h8000000000000000, 2'b01, 64'h008, "R7 -0 dp");
    apply_check(64'h0000000000000000, 2'b01, 64'h010, "R7 +0 dp");
    apply_check(64'h000FFFFFFFFFFFFF, 2'b01, 64'h020, "R7 +sub dp");
    apply_check(64'h3FF0000000000000, 2'b01, 64'h040, "R7 +norm dp");
    apply_check(64'h7FF0000000000000, 2'b01, 64'h080, "R7 +inf dp");
    apply_check(64'h7FF0000000000001, 2'b01, 64'h100, "R7 snan dp");
    apply_check(64'h7FF8000000000000, 2'b01, 64'h200, "R7 qnan dp");
    apply_check(64'h000000007F800000, 2'b01, 64'h020, "R7 low word not single");
  endtask

  task automatic t_upper_ignored;
    apply_check(64'hFFFFFFFF_3F800000, 2'b00, 64'h040, "R6 upper ignored norm");
    apply_check(64'h7FF80000_00000000, 2'b00, 64'h010, "R6 upper ignored zero");
    apply_check(64'hFFF00000_80000000, 2'b00, 64'h008, "R6 upper ignored -0");
  endtask

  task automatic t_other_codes;
    apply_check(64'h00000000_7F800000, 2'b10, 64'h080, "R8 code10 as single");
    apply_check(64'h3FF00000_00000000, 2'b11, 64'h010, "R8 code11 as single");
    apply_check(64'h00000000_FF800001, 2'b11, 64'h100, "R8 code11 snan single");
  endtask

  task automatic t_exponent_edges;
    apply_check(64'h7F7FFFFF, 2'b00, 64'h040, "R9 max normal sp");
    apply_check(64'h00800000, 2'b00, 64'h040, "R9 min normal sp");
    apply_check(64'h807FFFFF, 2'b00, 64'h004, "R9 max subnormal sp");
    apply_check(64'hFFEFFFFFFFFFFFFF, 2'b01, 64'h002, "R9 max normal dp");
    apply_check(64'h0010000000000000, 2'b01, 64'h040, "R9 min normal dp");
    apply_check(64'h7FFFFFFFFFFFFFFF, 2'b01, 64'h200, "R9 all ones dp");
  endtask

  task automatic t_sweep;
    logic [63:0] w;
    w = 64'h9E3779B97F4A7C15;
    for (int i = 0; i < 200; i++) begin
      w = w ^ (w << 13); w = w ^ (w >> 7); w = w ^ (w << 17);
      if (i % 4 == 0) w[62:52] = (i % 8 == 0) ? 11'h7FF : 11'h000;
      if (i % 4 == 1) w[30:23] = (i % 8 == 1) ? 8'hFF : 8'h00;
      apply_check(w, 2'(i % 4), want(w, 2'(i % 4)), "R9 sweep");
    end
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    operand = '0; fmt = 2'b00; rst = 1'b1;
    t_reset_state();
    t_single_classes();
    t_double_classes();
    t_upper_ignored();
    t_other_codes();
    t_exponent_edges();
    t_sweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule